// File: doc/BRIEF.md
# Rate-Estimating Victim Selector for a Four-Way Set-Associative Cache

This block decides which way of a four-way set-associative cache is replaced on a fill. Rather than keeping a recency order, it treats the references to each resident line as a Poisson arrival process. It estimates each line's arrival rate by maximum likelihood, which for this process is the mean: the number of hits the line received since it was filled, divided by the number of accesses its set saw over the same span. The line with the smallest estimate is the least likely to be referenced next, so it becomes the victim.

Each set holds one access counter that advances on every access to the set. Each way holds a hit counter and a snapshot of the set counter taken when the way was filled, so the way's age is the current set count minus its snapshot. The cache pipeline reports every access with its set, a hit flag and the hit way. When it needs a line it raises a fill request for a set. One cycle later the block returns the chosen way and has already marked that way as filled: its hit counter is cleared and its snapshot is taken. An access raised in the same cycle as a fill is dropped. Set count and counter width are parameters.

Top module: `poisson_victim_sel`

## Requirements
- R1: After reset `victimValid` is 0 and every way of every set is empty.
- R2: `victimValid` is 1 in exactly the cycle after a cycle with `fillReq` high, and 0 otherwise. `victimWay` carries the chosen way in that cycle.
- R3: When the requested set has an empty way, the lowest-numbered empty way is chosen. A fill marks the chosen way as occupied, so a fresh set fills in the order 0, 1, 2, 3.
- R4: When all four ways are occupied, the victim is the way whose hit count divided by its age is the lowest. Hit count is the hits on the way since its fill. Age is the accesses to the set since that fill, counting misses and hits on other ways.
- R5: The ranking uses the ratio and not the raw hit count. A recently filled way with few hits but a short age outranks an older way that has more hits but a lower ratio.
- R6: A way of age zero counts as having the highest rate. It is never chosen while another occupied way has a finite rate.
- R7: A fill clears the chosen way's hit count and sets its snapshot to the current set count, so history from before the refill does not count.
- R8: When several ways share the lowest rate, the victim is one of them, picked by a free-running 16-bit pseudo-random register with a nonzero seed. Different ways are picked over repeated identical situations.
- R9: Counters never wrap. An access that finds the set counter at its maximum first halves the set counter, every hit count and every snapshot of that set, then applies its own increments. The ordering of rates is kept.
- R10: Accesses change only the counters of the set they name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe for one cycle |
| accSet | input | SET_W | Set index of the access |
| accHit | input | 1 | The access hit in `accWay` |
| accWay | input | 2 | Way that hit |
| fillReq | input | 1 | Request a victim for `fillSet` and refill it |
| fillSet | input | SET_W | Set index of the fill |
| victimValid | output | 1 | Victim result valid |
| victimWay | output | 2 | Chosen victim way |

## Verification
A fresh set is filled four times to show the empty-way order. Skewed hit patterns then tell a ratio-based ranking apart from a raw-count one, and a refill followed by a few accesses shows that history is discarded. Accesses to a neighbouring set are placed between steps; they would move the victim if they leaked across sets. Patterns with exactly two equal lowest rates check that the pick stays inside the tied pair. A long run with staggered fill times pushes the set counter past its maximum, where a wrapping counter would invert the ranking.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);

  typedef logic [WAY_W-1:0] wayIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    accEn;
    logic    fillEn;
    wayIdx_t fillWay;
  } pvsStrobe_t;
endpackage

// File: rtl/pvs_datapath.sv
module pvs_datapath
  import pvs_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int CNT_W    = 8,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pvsStrobe_t                    strobe,
  input  logic [SET_W-1:0]              accSet,
  input  logic                          accHit,
  input  wayIdx_t                       accWay,
  input  logic [SET_W-1:0]              fillSet,
  output logic [CNT_W-1:0]              rdGlobal,
  output logic [WAYS-1:0][CNT_W-1:0]    rdLocal,
  output logic [WAYS-1:0][CNT_W-1:0]    rdSnap,
  output logic [WAYS-1:0]               rdValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]           globalQ [NUM_SETS];
  logic [CNT_W-1:0]           globalD [NUM_SETS];
  logic [WAYS-1:0][CNT_W-1:0] localQ  [NUM_SETS];
  logic [WAYS-1:0][CNT_W-1:0] localD  [NUM_SETS];
  logic [WAYS-1:0][CNT_W-1:0] snapQ   [NUM_SETS];
  logic [WAYS-1:0][CNT_W-1:0] snapD   [NUM_SETS];
  logic [WAYS-1:0]            validQ  [NUM_SETS];
  logic [WAYS-1:0]            validD  [NUM_SETS];

  always_comb begin
    logic halve;
    for (int s = 0; s < NUM_SETS; s++) begin
      globalD[s] = globalQ[s];
      localD[s]  = localQ[s];
      snapD[s]   = snapQ[s];
      validD[s]  = validQ[s];
      halve      = 1'b0;
      if (strobe.fillEn && fillSet == SET_W'(s)) begin
        validD[s][strobe.fillWay] = 1'b1;
        localD[s][strobe.fillWay] = '0;
        snapD[s][strobe.fillWay]  = globalQ[s];
      end else if (strobe.accEn && accSet == SET_W'(s)) begin
        halve = (globalQ[s] == CNT_MAX);
        if (halve) begin
          globalD[s] = (globalQ[s] >> 1) + 1'b1;
          for (int w = 0; w < WAYS; w++) begin
            localD[s][w] = localQ[s][w] >> 1;
            snapD[s][w]  = snapQ[s][w] >> 1;
          end
        end else begin
          globalD[s] = globalQ[s] + 1'b1;
        end
        if (accHit && localD[s][accWay] != CNT_MAX)
          localD[s][accWay] = localD[s][accWay] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SETS; s++) begin
      if (!rstN) begin
        globalQ[s] <= '0;
        localQ[s]  <= '0;
        snapQ[s]   <= '0;
        validQ[s]  <= '0;
      end else begin
        globalQ[s] <= globalD[s];
        localQ[s]  <= localD[s];
        snapQ[s]   <= snapD[s];
        validQ[s]  <= validD[s];
      end
    end
  end

  assign rdGlobal = globalQ[fillSet];
  assign rdLocal  = localQ[fillSet];
  assign rdSnap   = snapQ[fillSet];
  assign rdValid  = validQ[fillSet];

  // R7: a filled way starts with no hits and is marked occupied
  p_fill_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> (localQ[$past(fillSet)][$past(strobe.fillWay)] == '0)
                      && validQ[$past(fillSet)][$past(strobe.fillWay)]);

  // R9: the set counter never wraps back to zero after an access
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accEn |=> globalQ[$past(accSet)] != '0);

  // R9: the counter only steps down through the halving rule
  p_halve_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accEn && globalQ[accSet] != CNT_MAX) |=>
      globalQ[$past(accSet)] == $past(globalQ[accSet]) + 1'b1);
endmodule

// File: rtl/pvs_ctrl.sv
module pvs_ctrl
  import pvs_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       accValid,
  input  logic                       fillReq,
  input  logic [CNT_W-1:0]           rdGlobal,
  input  logic [WAYS-1:0][CNT_W-1:0] rdLocal,
  input  logic [WAYS-1:0][CNT_W-1:0] rdSnap,
  input  logic [WAYS-1:0]            rdValid,
  output pvsStrobe_t                 strobe,
  output logic                       victimValid,
  output wayIdx_t                    victimWay
);
  localparam int PROD_W = 2 * CNT_W;

  logic [15:0]                lfsrQ;
  logic [WAYS-1:0][CNT_W-1:0] age;
  logic [WAYS-1:0]            candMask;
  wayIdx_t                    tiePick, invPick, chosen;
  logic                       anyEmpty;

  // true when rate A (lA/aA) is strictly below rate B (lB/aB); age zero means unbounded rate
  function automatic logic rateBelow(input logic [CNT_W-1:0] lA, aA, lB, aB);
    logic [PROD_W-1:0] pA, pB;
    pA = {{CNT_W{1'b0}}, lA} * {{CNT_W{1'b0}}, aB};
    pB = {{CNT_W{1'b0}}, lB} * {{CNT_W{1'b0}}, aA};
    if (aA == '0)      return 1'b0;
    else if (aB == '0) return 1'b1;
    else               return pA < pB;
  endfunction

  always_comb begin
    for (int w = 0; w < WAYS; w++) age[w] = rdGlobal - rdSnap[w];
  end

  // ways that no other way beats on rate
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      candMask[i] = 1'b1;
      for (int j = 0; j < WAYS; j++)
        if (j != i && rateBelow(rdLocal[j], age[j], rdLocal[i], age[i]))
          candMask[i] = 1'b0;
    end
  end

  always_comb begin
    logic    found;
    wayIdx_t idx;
    tiePick = '0;
    found   = 1'b0;
    for (int k = 0; k < WAYS; k++) begin
      idx = lfsrQ[WAY_W-1:0] + WAY_W'(k);
      if (!found && candMask[idx]) begin
        tiePick = idx;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    invPick = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!rdValid[w]) invPick = WAY_W'(w);
  end

  assign anyEmpty = ~&rdValid;
  assign chosen   = anyEmpty ? invPick : tiePick;

  assign strobe.accEn   = accValid && !fillReq;
  assign strobe.fillEn  = fillReq;
  assign strobe.fillWay = chosen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ       <= LFSR_SEED;
      victimValid <= 1'b0;
      victimWay   <= '0;
    end else begin
      lfsrQ       <= {1'b0, lfsrQ[15:1]} ^ (lfsrQ[0] ? 16'hB400 : 16'h0000);
      victimValid <= fillReq;
      if (fillReq) victimWay <= chosen;
    end
  end

  // R2: result appears exactly one cycle after the request
  p_result_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |=> victimValid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !fillReq |=> !victimValid);

  // R3: an empty way 0 is always taken first
  p_empty_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !rdValid[0]) |=> victimWay == '0);

  // R8: the random source never locks up at zero
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  // R4, R6: a way beaten on rate by another way is never chosen in a full set
  for (genvar w = 0; w < WAYS; w++) begin : g_minChk
    p_min_rate_r4: assert property (@(posedge clk) disable iff (!rstN)
      (fillReq && &rdValid && !candMask[w]) |=> victimWay != WAY_W'(w));
  end
endmodule

// File: rtl/poisson_victim_sel.sv
module poisson_victim_sel
  import pvs_pkg::*;
#(
  parameter int          NUM_SETS  = 16,
  parameter int          CNT_W     = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         SET_W     = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic             accHit,
  input  logic [1:0]       accWay,
  input  logic             fillReq,
  input  logic [SET_W-1:0] fillSet,
  output logic             victimValid,
  output logic [1:0]       victimWay
);
  pvsStrobe_t                 strobe;
  logic [CNT_W-1:0]           rdGlobal;
  logic [WAYS-1:0][CNT_W-1:0] rdLocal, rdSnap;
  logic [WAYS-1:0]            rdValid;

  pvs_datapath #(.NUM_SETS(NUM_SETS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accSet(accSet), .accHit(accHit), .accWay(accWay), .fillSet(fillSet),
    .rdGlobal(rdGlobal), .rdLocal(rdLocal), .rdSnap(rdSnap), .rdValid(rdValid)
  );

  pvs_ctrl #(.CNT_W(CNT_W), .LFSR_SEED(LFSR_SEED)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .fillReq(fillReq),
    .rdGlobal(rdGlobal), .rdLocal(rdLocal), .rdSnap(rdSnap), .rdValid(rdValid),
    .strobe(strobe), .victimValid(victimValid), .victimWay(victimWay)
  );
endmodule

// File: tb/poisson_victim_sel_bench.sv
`timescale 1ns/1ps
module poisson_victim_sel_bench;
  localparam int NUM_SETS = 16;
  localparam int SET_W    = $clog2(NUM_SETS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             accValid = 1'b0;
  logic [SET_W-1:0] accSet = '0;
  logic             accHit = 1'b0;
  logic [1:0]       accWay = '0;
  logic             fillReq = 1'b0;
  logic [SET_W-1:0] fillSet = '0;
  logic             victimValid;
  logic [1:0]       victimWay;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastVictim = 0;
  bit finished = 1'b0;

  logic [3:0] expMask[$];
  int         expDue[$];
  string      expTag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  poisson_victim_sel #(.NUM_SETS(NUM_SETS)) u_poisson_victim_sel (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accWay(accWay), .fillReq(fillReq), .fillSet(fillSet),
    .victimValid(victimValid), .victimWay(victimWay)
  );

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (victimValid) begin
        if (expMask.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected result way=%0d at cycle %0d, expected none", victimWay, cyc);
        end else begin
          logic [3:0] m; int d; string t;
          m = expMask.pop_front(); d = expDue.pop_front(); t = expTag.pop_front();
          checks++;
          if (!m[victimWay] || d != cyc) begin
            errors++;
            $display("FAIL %s: way=%0d cycle=%0d, expected mask=%b cycle=%0d", t, victimWay, cyc, m, d);
          end
          lastVictim = victimWay;
        end
      end else if (expDue.size() > 0 && expDue[0] < cyc) begin
        checks++; errors++;
        $display("FAIL R2: missing result for %s, actual none, expected at cycle %0d", expTag[0], expDue[0]);
        void'(expMask.pop_front()); void'(expDue.pop_front()); void'(expTag.pop_front());
      end
    end
  end

  task automatic doFill(input int s, input logic [3:0] okMask, input string tag);
    @(negedge clk);
    accValid = 1'b0; fillReq = 1'b1; fillSet = SET_W'(s);
    expMask.push_back(okMask); expDue.push_back(cyc + 1); expTag.push_back(tag);
    @(negedge clk);
    fillReq = 1'b0;
  endtask

  task automatic doAcc(input int s, input logic hit, input int w);
    @(negedge clk);
    fillReq = 1'b0; accValid = 1'b1; accSet = SET_W'(s); accHit = hit; accWay = 2'(w);
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0; fillReq = 1'b0;
  endtask

  task automatic fillFresh(input int s);
    for (int w = 0; w < 4; w++) doFill(s, 4'(1 << w), "R3 empty-way order");
  endtask

  task automatic hits(input int s, input int w, input int n);
    for (int i = 0; i < n; i++) doAcc(s, 1'b1, w);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (victimValid !== 1'b0) begin
      errors++; $display("FAIL R1: victimValid=%b after reset, expected 0", victimValid);
    end

    // R3, R4, R5: set 2
    fillFresh(2);
    hits(2, 0, 5); hits(2, 1, 4); hits(2, 2, 3); hits(2, 3, 1);
    doFill(2, 4'b1000, "R4 lowest rate");
    hits(2, 3, 2);
    doFill(2, 4'b0100, "R5 ratio over count");
    idle();

    // R8, R6: set 3, two-way tie
    fillFresh(3);
    hits(3, 0, 2); hits(3, 2, 2); hits(3, 1, 1); hits(3, 3, 1);
    doFill(3, 4'b1010, "R8 tie inside pair");
    idle(); idle();
    doFill(3, 4'b1010 & ~4'(1 << lastVictim), "R6 fresh way protected");
    idle();

    // R7, R10: set 5 with traffic to set 6
    fillFresh(5);
    hits(5, 0, 1); hits(5, 1, 3); hits(5, 2, 3); hits(5, 3, 3);
    doFill(5, 4'b0001, "R4 fewest hits");
    hits(6, 0, 5);
    hits(5, 1, 1); hits(5, 2, 1); hits(5, 3, 1);
    doFill(5, 4'b0001, "R7 R10 history cleared and set isolation");
    idle();

    // R9: set 7, staggered fill then counter saturation
    doFill(7, 4'b0001, "R3 empty-way order");
    doFill(7, 4'b0010, "R3 empty-way order");
    doFill(7, 4'b0100, "R3 empty-way order");
    for (int i = 0; i < 200; i++) begin
      if (i % 4 == 3) doAcc(7, 1'b0, 0);
      else            doAcc(7, 1'b1, i % 4);
    end
    doFill(7, 4'b1000, "R3 empty-way order");
    for (int i = 0; i < 100; i++) begin
      case (i % 4)
        0, 1:    doAcc(7, 1'b1, 3);
        2:       doAcc(7, 1'b1, 0);
        default: doAcc(7, 1'b1, 1);
      endcase
    end
    doFill(7, 4'b0100, "R9 no wrap, ranking kept");
    doFill(7, 4'b0011, "R9 after halving");
    idle();

    // R8: spread over repeated full ties
    begin
      logic [3:0] seen;
      seen = '0;
      for (int s = 8; s < 14; s++) begin
        fillFresh(s);
        doAcc(s, 1'b0, 0);
        doFill(s, 4'b1111, "R8 full tie");
        idle(); idle();
        seen[lastVictim] = 1'b1;
      end
      checks++;
      if ($countones(seen) < 2) begin
        errors++; $display("FAIL R8: distinct tie picks=%0d, expected at least 2", $countones(seen));
      end
    end

    repeat (3) idle();
    checks++;
    if (expMask.size() != 0) begin
      errors++; $display("FAIL R2: %0d results outstanding, expected 0", expMask.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R2: watchdog expired, actual hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule